// File: doc/BRIEF.md
# Framed Serial Byte Receiver with Host-Clocked Readout

This block takes a demodulated 1200 baud asynchronous bit stream and recovers one eight-bit character at a time. It oversamples the line at sixteen times the baud rate and checks the start bit at its centre. It then samples each data bit and the stop bit at their centres. A character whose stop bit reads low is thrown away. A good character is written into a one-byte holding register.

A good character also drives the active-low ready line low. The host responds with rising edges on its own clock pin. Each rising edge moves the next bit onto the serial output, least significant bit first. The lowest bit is already on the output when ready falls. The first host edge after ready falls sends ready high again. If the host stays idle, ready returns high by itself after half a bit time. Reception is enabled only while the carrier qualifier is high.

The two line inputs and the host clock are asynchronous to the system clock. The block synchronises them internally.

Top module: `cid_byte_rx`

## Requirements
- R1: After reset, `rdy_n` is 1, `overrun` is 0 and `ser_out` is 0.
- R2: A character consists of a low start bit, eight data bits sent least significant first, and a high stop bit. After each such character, `rdy_n` falls once and `ser_out` shows data bit 0. On the k-th rising edge of `host_clk` (k = 1 to 7), `ser_out` advances to data bit k.
- R3: The first rising edge of `host_clk` after `rdy_n` falls returns `rdy_n` to 1.
- R4: If `host_clk` has no rising edge, `rdy_n` returns to 1 after half a bit time (8 oversampling ticks). The buffered byte can still be read afterwards.
- R5: A low pulse on `fsk_bit` that ends before the start bit's mid-point produces no character.
- R6: A character whose stop bit samples low is discarded, and `rdy_n` stays 1.
- R7: While `carrier_ok` is 0, no character is received and `rdy_n` stays 1.
- R8: A new character that completes before the host has given eight rising edges overwrites the buffer and sets `overrun`. `overrun` then stays 1 until reset. A character that arrives after a complete read leaves `overrun` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsk_bit | input | 1 | Demodulated serial line, idle high |
| carrier_ok | input | 1 | Carrier qualifier; high enables reception |
| host_clk | input | 1 | Host shift clock; rising edges advance the output |
| ser_out | output | 1 | Current buffered bit for the host |
| rdy_n | output | 1 | Active-low byte-ready |
| overrun | output | 1 | Sticky flag: a byte was overwritten before it was read |

## Verification
The byte values used are 0xA5, 0x3C, 0x00, 0xFF and 0x80. Together they separate bit order from bit polarity and expose a stuck or swapped data bit. The ready line is exercised three ways: read fully, cleared by a single edge, and left unserviced. These cases separate an edge-cleared release from a timed release. Stimulus that must not yield a byte is also applied: a short start glitch, a low stop bit, and a character sent with the carrier low. Each of these is checked against a count of ready falling edges. Overrun is checked in two orders: an unread byte followed by another byte, and a fully read byte followed by another byte.

// File: rtl/cid_rx_pkg.sv
package cid_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/cid_sync.sv
module cid_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= {STAGES{RST_VAL}};
    else        st_q <= {st_q[STAGES-2:0], d};
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/cid_tick_gen.sv
module cid_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == LAST);

  p_tick_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick || (DIV == 1));
endmodule

// File: rtl/cid_frame_rx.sv
module cid_frame_rx
  import cid_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DB  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_s,
  input  logic          cd_s,
  output logic          byte_vld,
  output logic [DB-1:0] byte_data
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DB);
  localparam logic [CW-1:0] PH_MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] PH_END  = CW'(OVS - 1);
  localparam logic [BW-1:0] BIT_END = BW'(DB - 1);

  rx_state_e     st_q, st_d;
  logic [CW-1:0] ph_q, ph_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DB-1:0] sh_q, sh_d;
  logic [DB-1:0] dat_q, dat_d;
  logic          vld_q, vld_d;

  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    dat_d = dat_q;
    vld_d = 1'b0;
    if (!cd_s) begin
      st_d = RX_IDLE;
    end else begin
      unique case (st_q)
        RX_IDLE: begin
          if (!rx_s) begin
            st_d = RX_START;
            ph_d = '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (ph_q == PH_MID) begin
              ph_d  = '0;
              bit_d = '0;
              st_d  = rx_s ? RX_IDLE : RX_DATA;
            end else begin
              ph_d = ph_q + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (ph_q == PH_END) begin
              ph_d = '0;
              sh_d = {rx_s, sh_q[DB-1:1]};
              if (bit_q == BIT_END) st_d = RX_STOP;
              else                  bit_d = bit_q + 1'b1;
            end else begin
              ph_d = ph_q + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (ph_q == PH_END) begin
              st_d = RX_IDLE;
              if (rx_s) begin
                vld_d = 1'b1;
                dat_d = sh_q;
              end
            end else begin
              ph_d = ph_q + 1'b1;
            end
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      ph_q  <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      dat_q <= '0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      dat_q <= dat_d;
      vld_q <= vld_d;
    end
  end

  assign byte_vld  = vld_q;
  assign byte_data = dat_q;

  p_cd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cd_s |=> (st_q == RX_IDLE) && !vld_q);
  p_stop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(rx_s));
  p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
endmodule

// File: rtl/cid_host_port.sv
module cid_host_port #(
  parameter int DB   = 8,
  parameter int HALF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic [DB-1:0] ld_data,
  input  logic          hclk_s,
  output logic          sdo,
  output logic          dr_n,
  output logic          ovr
);
  localparam int LW = $clog2(DB + 1);
  localparam int TW = $clog2(HALF + 1);
  localparam logic [LW-1:0] LEFT_FULL = LW'(DB);
  localparam logic [TW-1:0] TMO_FULL  = TW'(HALF);
  localparam logic [TW-1:0] TMO_ONE   = TW'(1);

  logic [DB-1:0] buf_q, buf_d;
  logic [LW-1:0] left_q, left_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic          dr_q, dr_d;
  logic          ovr_q, ovr_d;
  logic          hprev_q;
  logic          rise;

  assign rise = hclk_s & ~hprev_q;

  always_comb begin
    buf_d  = buf_q;
    left_d = left_q;
    tmo_d  = tmo_q;
    dr_d   = dr_q;
    ovr_d  = ovr_q;
    if (load) begin
      buf_d  = ld_data;
      left_d = LEFT_FULL;
      dr_d   = 1'b0;
      tmo_d  = TMO_FULL;
      if (left_q != '0) ovr_d = 1'b1;
    end else if (rise) begin
      dr_d = 1'b1;
      if (left_q != '0) begin
        buf_d  = buf_q >> 1;
        left_d = left_q - 1'b1;
      end
    end else if (!dr_q && tick) begin
      if (tmo_q == TMO_ONE) dr_d = 1'b1;
      tmo_d = tmo_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= '0;
      left_q  <= '0;
      tmo_q   <= '0;
      dr_q    <= 1'b1;
      ovr_q   <= 1'b0;
      hprev_q <= 1'b0;
    end else begin
      buf_q   <= buf_d;
      left_q  <= left_d;
      tmo_q   <= tmo_d;
      dr_q    <= dr_d;
      ovr_q   <= ovr_d;
      hprev_q <= hclk_s;
    end
  end

  assign sdo  = buf_q[0];
  assign dr_n = dr_q;
  assign ovr  = ovr_q;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!dr_n && (sdo == $past(ld_data[0]))));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !dr_n && !load) |=> dr_n);
  p_tmo_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_n |-> (tmo_q != '0));
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> ovr);
endmodule

// File: rtl/cid_byte_rx.sv
module cid_byte_rx #(
  parameter int CLK_HZ = 50_000_000,
  parameter int BAUD   = 1200,
  parameter int OVS    = 16,
  parameter int DB     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsk_bit,
  input  logic carrier_ok,
  input  logic host_clk,
  output logic ser_out,
  output logic rdy_n,
  output logic overrun
);
  localparam int DIV  = CLK_HZ / (BAUD * OVS);
  localparam int HALF = OVS / 2;

  logic [1:0]    rst_q;
  logic          srst_n;
  logic [2:0]    in_s;
  logic          tick;
  logic          vld;
  logic [DB-1:0] data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign srst_n = rst_q[1];

  cid_sync #(.W(3), .STAGES(2), .RST_VAL(3'b001)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d     ({host_clk, carrier_ok, fsk_bit}),
    .q     (in_s)
  );

  cid_tick_gen #(.DIV(DIV)) u_tick (
    .clk   (clk),
    .rst_n (srst_n),
    .tick  (tick)
  );

  cid_frame_rx #(.OVS(OVS), .DB(DB)) u_frame (
    .clk       (clk),
    .rst_n     (srst_n),
    .tick      (tick),
    .rx_s      (in_s[0]),
    .cd_s      (in_s[1]),
    .byte_vld  (vld),
    .byte_data (data)
  );

  cid_host_port #(.DB(DB), .HALF(HALF)) u_host (
    .clk     (clk),
    .rst_n   (srst_n),
    .tick    (tick),
    .load    (vld),
    .ld_data (data),
    .hclk_s  (in_s[2]),
    .sdo     (ser_out),
    .dr_n    (rdy_n),
    .ovr     (overrun)
  );
endmodule

// File: tb/sim_cid_byte_rx.sv
module sim_cid_byte_rx;
  localparam int BIT_CYC = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsk_bit = 1'b1;
  logic carrier_ok = 1'b1;
  logic host_clk = 1'b0;
  logic ser_out, rdy_n, overrun;

  int n_run = 0;
  int n_fail = 0;
  int falls = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cid_byte_rx #(.CLK_HZ(50_000_000), .BAUD(781_250)) u0 (
    .clk(clk), .rst_n(rst_n), .fsk_bit(fsk_bit), .carrier_ok(carrier_ok),
    .host_clk(host_clk), .ser_out(ser_out), .rdy_n(rdy_n), .overrun(overrun)
  );

  always @(negedge rdy_n) if (rst_n) falls++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] b, input logic stop);
    fsk_bit = 1'b0; wcyc(BIT_CYC);
    for (int i = 0; i < 8; i++) begin
      fsk_bit = b[i]; wcyc(BIT_CYC);
    end
    fsk_bit = stop; wcyc(48);
    fsk_bit = 1'b1;
  endtask

  task automatic read_byte(output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      v[i] = ser_out;
      host_clk = 1'b1; wcyc(6);
      host_clk = 1'b0; wcyc(6);
    end
  endtask

  task automatic t_reset;
    chk(rdy_n == 1'b1, "R1 rdy_n", rdy_n, 1);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    chk(ser_out == 1'b0, "R1 ser_out", ser_out, 0);
  endtask

  task automatic t_basic(input logic [7:0] b);
    logic [7:0] v;
    int f0 = falls;
    send_char(b, 1'b1);
    chk(rdy_n == 1'b0, "R2 rdy_n low", rdy_n, 0);
    chk(falls == f0 + 1, "R2 one fall", falls, f0 + 1);
    chk(ser_out == b[0], "R2 first bit", ser_out, b[0]);
    read_byte(v);
    chk(v == b, "R2 byte", v, b);
    chk(rdy_n == 1'b1, "R3 after read", rdy_n, 1);
  endtask

  task automatic t_clear;
    logic [7:0] b = 8'h96;
    send_char(b, 1'b1);
    chk(rdy_n == 1'b0, "R3 low before edge", rdy_n, 0);
    host_clk = 1'b1; wcyc(5);
    chk(rdy_n == 1'b1, "R3 edge clears", rdy_n, 1);
    chk(ser_out == b[1], "R2 second bit", ser_out, b[1]);
    host_clk = 1'b0; wcyc(6);
    for (int i = 1; i < 8; i++) begin
      host_clk = 1'b1; wcyc(6);
      host_clk = 1'b0; wcyc(6);
    end
  endtask

  task automatic t_timeout;
    logic [7:0] v;
    send_char(8'h5A, 1'b1);
    chk(rdy_n == 1'b0, "R4 low before release", rdy_n, 0);
    wcyc(40);
    chk(rdy_n == 1'b1, "R4 self release", rdy_n, 1);
    read_byte(v);
    chk(v == 8'h5A, "R4 byte kept", v, 8'h5A);
  endtask

  task automatic t_glitch;
    int f0 = falls;
    fsk_bit = 1'b0; wcyc(12);
    fsk_bit = 1'b1; wcyc(12 * BIT_CYC);
    chk(falls == f0, "R5 glitch ignored", falls, f0);
    chk(rdy_n == 1'b1, "R5 rdy_n", rdy_n, 1);
  endtask

  task automatic t_badstop;
    int f0 = falls;
    send_char(8'hC3, 1'b0);
    wcyc(2 * BIT_CYC);
    chk(falls == f0, "R6 bad stop dropped", falls, f0);
    chk(rdy_n == 1'b1, "R6 rdy_n", rdy_n, 1);
  endtask

  task automatic t_nocarrier;
    int f0 = falls;
    carrier_ok = 1'b0; wcyc(4);
    send_char(8'h42, 1'b1);
    wcyc(BIT_CYC);
    chk(falls == f0, "R7 no carrier", falls, f0);
    chk(rdy_n == 1'b1, "R7 rdy_n", rdy_n, 1);
    carrier_ok = 1'b1; wcyc(4);
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    chk(overrun == 1'b0, "R8 no false overrun", overrun, 0);
    send_char(8'h11, 1'b1);
    wcyc(BIT_CYC);
    chk(overrun == 1'b0, "R8 single byte", overrun, 0);
    send_char(8'h22, 1'b1);
    chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
    read_byte(v);
    chk(v == 8'h22, "R8 overwritten", v, 8'h22);
    send_char(8'h33, 1'b1);
    read_byte(v);
    chk(v == 8'h33, "R8 next byte", v, 8'h33);
    chk(overrun == 1'b1, "R8 sticky", overrun, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    wcyc(5);
    rst_n = 1'b1;
    wcyc(5);
    t_reset();
    t_basic(8'hA5);
    t_basic(8'h3C);
    t_basic(8'h00);
    t_basic(8'hFF);
    t_basic(8'h80);
    t_clear();
    t_timeout();
    t_glitch();
    t_badstop();
    t_nocarrier();
    t_basic(8'h69);
    t_overrun();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule